// File: doc/BRIEF.md
# BCD Calendar Counter with Busy Window

This block is the timekeeping core of a real-time clock. A one-cycle `tick` strobe arrives at 32768 Hz in the system clock domain. A prescaler counts these strobes. Each time it completes a second, and only while the run bit is set, the calendar advances. The calendar holds seconds, minutes, hours, day of month, month, a two-digit year (00..99, meaning 2000..2099) and a weekday, each as a packed BCD byte. Carries ripple through the whole calendar, including month lengths and leap years.

Software reaches the block through a plain byte-wide register port. Writes are single-cycle strobes and reads are combinational on the address, so there is no valid/ready handshake and no back-pressure. A BUSY status bit is high for the whole last tick period before each update. Software can poll for BUSY to fall and then has most of a tick period to access the counters safely. The four sticky event flags (second, minute, hour, day) record rollovers. The second flag can be routed to a level interrupt.

Field offsets: seconds 0x00, minutes 0x04, hours 0x08, day 0x0C, month 0x10, year 0x14, weekday 0x18. The control register is at 0x40, status at 0x44 and interrupt enable at 0x48.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the fields read seconds, minutes and hours 0x00, day 0x01, month 0x01, year 0x00 and weekday 0x00. Control, status and interrupt enable all read 0x00, and `irq_timer` is low.
- R2: Control bit 0 is the run bit. The prescaler and the calendar advance only while it is 1. Status bit 1 reads back the run bit.
- R3: While running, every TICKS_PER_SEC ticks cause one update, and seconds count up in BCD. Seconds 0x59 wrap to 0x00 and carry into minutes. Minutes 0x59 wrap and carry into hours. Hours 0x23 wrap and carry into the day and into the weekday, which counts 0x00..0x06 and then wraps.
- R4: The day wraps to 0x01 after 0x30 in months 0x04, 0x06, 0x09 and 0x11. In February it wraps after 0x29 when the BCD year is a multiple of four, otherwise after 0x28. In all other months it wraps after 0x31. On a day wrap, the month goes from 0x12 to 0x01 and carries into the year, and the year goes from 0x99 to 0x00.
- R5: Status bit 0 (BUSY) is high exactly while running with the prescaler at its last count (TICKS_PER_SEC-1). It falls in the cycle after the tick that performs the update.
- R6: Status bits 2, 3, 4 and 5 are sticky flags for the second, minute, hour and day updates. Each is set by the update that produces its event. Writing 1 to a flag bit at 0x44 clears it. A set in the same cycle as a clear wins.
- R7: Writing a field offset loads that byte verbatim on the next clock. Reading a field offset returns the packed BCD value.
- R8: A field write in the same cycle as an update wins for that field only. The other fields still advance, using carries computed from the values held before the update.
- R9: The control register reads back all 8 bits written, and only bit 0 affects behaviour. Bit 2 at 0x48 is the timer interrupt enable; the other bits of that register read 0. `irq_timer` = enable AND the second-event flag.
- R10: Addresses other than the ten listed read 0x00, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle 32768 Hz strobe |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq_timer | output | 1 | Level timer interrupt |

## Verification
The hardest case to reach from the ports is a register write that lands on the exact tick that performs an update. Hitting it means knowing the prescaler phase, which is visible only through BUSY. The bench tracks the phase in its reference model. It issues the write, or a flag clear, on the cycle where the model says the next tick completes a second. Multi-level carries (year end, the February leap rules, 30-day months) are reached by stopping the clock, preloading a time a few seconds before the boundary, and restarting it.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int NUM_FIELDS = 7;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_MON  = 4;
  localparam int F_YEAR = 5;
  localparam int F_WDAY = 6;
  localparam int NUM_EVT = 4;

  localparam logic [7:0] ADR_CTRL = 8'h40;
  localparam logic [7:0] ADR_STAT = 8'h44;
  localparam logic [7:0] ADR_INTR = 8'h48;
  localparam int TMR_EN_BIT = 2;

  function automatic logic [7:0] field_lo(input int idx);
    return (idx == F_DAY || idx == F_MON) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    return (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic bcd_leap(input logic [7:0] y);
    if (y[4])
      return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02: return bcd_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  output logic busy,
  output logic sec_stb
);
  localparam int CNT_W = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic at_last;

  assign at_last = (cnt_q == LAST);
  assign busy    = run && at_last;
  assign sec_stb = run && tick && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (run && tick)
      cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter logic [7:0] RST_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc,
  input  logic [7:0] lo,
  input  logic [7:0] hi,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] val,
  output logic       wrap
);
  import rtc_cal_pkg::*;

  logic at_top;
  assign at_top = (val >= hi);
  assign wrap   = inc && at_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      val <= RST_VAL;
    else if (wr)
      val <= wdata;
    else if (inc)
      val <= at_top ? lo : bcd_next(val);
  end
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_cal_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [7:0]                       bus_addr,
  input  logic                             bus_we,
  input  logic [7:0]                       bus_wdata,
  output logic [7:0]                       bus_rdata,
  input  logic [NUM_FIELDS-1:0][7:0]       fld_val,
  output logic [NUM_FIELDS-1:0]            fld_wr,
  input  logic                             busy,
  input  logic [NUM_EVT-1:0]               ev_set,
  output logic [NUM_EVT-1:0]               evt_q,
  output logic                             run,
  output logic                             irq_timer
);
  logic [7:0] ctrl_q;
  logic       ten_q;
  logic [NUM_EVT-1:0] ev_clr;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_dec
    assign fld_wr[g] = bus_we && (bus_addr == 8'(4 * g));
  end

  assign ev_clr    = (bus_we && bus_addr == ADR_STAT) ? bus_wdata[2 +: NUM_EVT] : '0;
  assign run       = ctrl_q[0];
  assign irq_timer = ten_q && evt_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ten_q  <= 1'b0;
      evt_q  <= '0;
    end else begin
      if (bus_we && bus_addr == ADR_CTRL) ctrl_q <= bus_wdata;
      if (bus_we && bus_addr == ADR_INTR) ten_q <= bus_wdata[TMR_EN_BIT];
      evt_q <= (evt_q & ~ev_clr) | ev_set;
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (bus_addr == 8'(4 * i)) bus_rdata = fld_val[i];
    case (bus_addr)
      ADR_CTRL: bus_rdata = ctrl_q;
      ADR_STAT: bus_rdata = {2'b00, evt_q, run, busy};
      ADR_INTR: bus_rdata = {5'b0, ten_q, 2'b00};
      default: ;
    endcase
  end
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [7:0] bus_addr,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq_timer
);
  logic run, busy, sec_stb;
  logic [NUM_FIELDS-1:0][7:0] fld_q;
  logic [NUM_FIELDS-1:0][7:0] lo_v, hi_v;
  logic [NUM_FIELDS-1:0]      inc_v, wrap, fld_wr;
  logic [NUM_EVT-1:0]         ev_set, evt_q;

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
    .busy(busy), .sec_stb(sec_stb)
  );

  // carry chain, driven from pre-update values
  assign inc_v[F_SEC]  = sec_stb;
  assign inc_v[F_MIN]  = wrap[F_SEC];
  assign inc_v[F_HOUR] = wrap[F_MIN];
  assign inc_v[F_DAY]  = wrap[F_HOUR];
  assign inc_v[F_MON]  = wrap[F_DAY];
  assign inc_v[F_YEAR] = wrap[F_MON];
  assign inc_v[F_WDAY] = wrap[F_HOUR];

  assign hi_v[F_SEC]  = 8'h59;
  assign hi_v[F_MIN]  = 8'h59;
  assign hi_v[F_HOUR] = 8'h23;
  assign hi_v[F_DAY]  = month_days(fld_q[F_MON], fld_q[F_YEAR]);
  assign hi_v[F_MON]  = 8'h12;
  assign hi_v[F_YEAR] = 8'h99;
  assign hi_v[F_WDAY] = 8'h06;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    assign lo_v[g] = field_lo(g);
    rtc_bcd_field #(.RST_VAL(field_lo(g))) u_field (
      .clk(clk), .rst_n(rst_n), .inc(inc_v[g]), .lo(lo_v[g]), .hi(hi_v[g]),
      .wr(fld_wr[g]), .wdata(bus_wdata), .val(fld_q[g]), .wrap(wrap[g])
    );
  end

  assign ev_set = {wrap[F_HOUR], wrap[F_MIN], wrap[F_SEC], sec_stb};

  rtc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fld_val(fld_q),
    .fld_wr(fld_wr), .busy(busy), .ev_set(ev_set), .evt_q(evt_q),
    .run(run), .irq_timer(irq_timer)
  );
endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
module rtc_bcd_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       run,
  input logic       busy,
  input logic       sec_stb,
  input logic [7:0] sec_q,
  input logic [7:0] mon_q,
  input logic [7:0] yr_q,
  input logic [6:0] wrap,
  input logic [6:0] fld_wr,
  input logic [3:0] evt_q,
  input logic [7:0] bus_wdata
);
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && fld_wr == 7'd0) |=> $stable(sec_q)); // R2
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_stb && sec_q == 8'h59 && !fld_wr[0]) |=> (sec_q == 8'h00)); // R3
  AST_MON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap[3] && mon_q == 8'h12 && !fld_wr[4]) |=> (mon_q == 8'h01)); // R4
  AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap[4] && yr_q == 8'h99 && !fld_wr[5]) |=> (yr_q == 8'h00)); // R4
  AST_BUSY_ONE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tick) |=> !busy); // R5
  AST_SEC_EVT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    sec_stb |=> evt_q[0]); // R6
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    fld_wr[0] |=> (sec_q == $past(bus_wdata))); // R8
endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .busy(busy),
  .sec_stb(sec_stb), .sec_q(fld_q[0]), .mon_q(fld_q[4]), .yr_q(fld_q[5]),
  .wrap(wrap), .fld_wr(fld_wr), .evt_q(evt_q), .bus_wdata(bus_wdata)
);

// File: tb/rtc_bcd_calendar_bench.sv
`timescale 1ns/1ps
module rtc_bcd_calendar_bench;
  localparam int TPS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic irq_timer;

  always #2 clk = ~clk;

  rtc_bcd_calendar #(.TICKS_PER_SEC(TPS)) u_rtc_bcd_calendar (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_timer(irq_timer)
  );

  // reference model (binary values)
  int m_sec, m_min, m_hr, m_day, m_mon, m_yr, m_wday, m_presc;
  logic [7:0] m_ctrl;
  bit m_ten;
  logic [3:0] m_evt;
  int n_cmp = 0, n_bad = 0, rot_i = 0;
  bit done = 0;
  string cur_req = "R1";

  function automatic logic [7:0] b2d(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int d2b(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction
  function automatic int dim(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction
  function automatic logic [7:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00: return b2d(m_sec);
      8'h04: return b2d(m_min);
      8'h08: return b2d(m_hr);
      8'h0C: return b2d(m_day);
      8'h10: return b2d(m_mon);
      8'h14: return b2d(m_yr);
      8'h18: return b2d(m_wday);
      8'h40: return m_ctrl;
      8'h44: return {2'b00, m_evt, m_ctrl[0], (m_ctrl[0] && m_presc == TPS - 1)};
      8'h48: return {5'b0, m_ten, 2'b00};
      default: return 8'h00;
    endcase
  endfunction
  function automatic logic [7:0] rot_addr(input int i);
    int k = i % 10;
    if (k < 7) return 8'(4 * k);
    if (k == 7) return 8'h40;
    if (k == 8) return 8'h44;
    return 8'h48;
  endfunction

  task automatic model_step(input bit tk, input bit we, input logic [7:0] a, input logic [7:0] d);
    bit upd = m_ctrl[0] && tk && (m_presc == TPS - 1);
    int s = m_sec, mi = m_min, h = m_hr, dy = m_day, mo = m_mon, y = m_yr, w = m_wday;
    logic [3:0] st = 4'b0, cl = 4'b0;
    if (m_ctrl[0] && tk) m_presc = (m_presc == TPS - 1) ? 0 : m_presc + 1;
    if (upd) begin
      st[0] = 1;
      if (m_sec >= 59) begin
        s = 0; st[1] = 1;
        if (m_min >= 59) begin
          mi = 0; st[2] = 1;
          if (m_hr >= 23) begin
            h = 0; st[3] = 1;
            w = (m_wday >= 6) ? 0 : m_wday + 1;
            if (m_day >= dim(m_mon, m_yr)) begin
              dy = 1;
              if (m_mon >= 12) begin mo = 1; y = (m_yr >= 99) ? 0 : m_yr + 1; end
              else mo = m_mon + 1;
            end else dy = m_day + 1;
          end else h = m_hr + 1;
        end else mi = m_min + 1;
      end else s = m_sec + 1;
    end
    if (we) begin
      case (a)
        8'h00: s = d2b(d);
        8'h04: mi = d2b(d);
        8'h08: h = d2b(d);
        8'h0C: dy = d2b(d);
        8'h10: mo = d2b(d);
        8'h14: y = d2b(d);
        8'h18: w = d2b(d);
        8'h40: m_ctrl = d;
        8'h44: cl = d[5:2];
        8'h48: m_ten = d[2];
        default: ;
      endcase
    end
    m_sec = s; m_min = mi; m_hr = h; m_day = dy; m_mon = mo; m_yr = y; m_wday = w;
    m_evt = (m_evt & ~cl) | st;
  endtask

  task automatic check_outputs();
    logic [7:0] e = exp_read(bus_addr);
    bit ei = m_ten && m_evt[0];
    n_cmp++;
    if (bus_rdata !== e) begin
      n_bad++;
      $display("FAIL %s addr=%02h rdata actual=%02h expected=%02h", cur_req, bus_addr, bus_rdata, e);
    end
    n_cmp++;
    if (irq_timer !== ei) begin
      n_bad++;
      $display("FAIL R9 irq_timer actual=%0b expected=%0b", irq_timer, ei);
    end
  endtask

  task automatic cyc(input bit tk, input bit we, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    check_outputs();
    tick = tk; bus_we = we; bus_addr = a; bus_wdata = d;
    model_step(tk, we, a, d);
  endtask

  task automatic idle(input int n, input int p);
    for (int i = 0; i < n; i++) begin
      cyc((i % p) == 0, 1'b0, rot_addr(rot_i), 8'h00);
      rot_i++;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cyc(1'b0, 1'b1, a, d);
  endtask

  task automatic set_time(input int y, input int mo, input int d, input int h, input int mi, input int s);
    wr(8'h40, 8'h00);
    wr(8'h14, b2d(y)); wr(8'h10, b2d(mo)); wr(8'h0C, b2d(d));
    wr(8'h08, b2d(h)); wr(8'h04, b2d(mi)); wr(8'h00, b2d(s));
    wr(8'h40, 8'h01);
  endtask

  task automatic collide(input logic [7:0] a, input logic [7:0] d);
    int guard = 0;
    while (!(m_ctrl[0] && m_presc == TPS - 1) && guard < 4 * TPS) begin
      cyc(1'b1, 1'b0, rot_addr(rot_i), 8'h00);
      rot_i++; guard++;
    end
    cyc(1'b1, 1'b1, a, d);
  endtask

  initial begin
    m_sec = 0; m_min = 0; m_hr = 0; m_day = 1; m_mon = 1; m_yr = 0; m_wday = 0;
    m_presc = 0; m_ctrl = 8'h00; m_ten = 0; m_evt = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; idle(12, 1000);
    cur_req = "R2"; idle(40, 1);               // ticks while stopped: no change
    cur_req = "R9"; wr(8'h40, 8'h8E); idle(10, 1); wr(8'h48, 8'h04); idle(10, 1);
    cur_req = "R3"; wr(8'h40, 8'h01); idle(TPS * 70, 1);
    cur_req = "R7"; wr(8'h08, 8'h23); wr(8'h04, 8'h59); wr(8'h00, 8'h55); idle(10, 1);
    cur_req = "R3"; idle(TPS * 8, 1);          // day and weekday carry
    cur_req = "R3"; wr(8'h18, 8'h06); set_time(0, 1, 5, 23, 59, 58); idle(TPS * 4, 1);
    cur_req = "R4"; set_time(23, 2, 28, 23, 59, 58); idle(TPS * 4, 1);
    cur_req = "R4"; set_time(24, 2, 28, 23, 59, 58); idle(TPS * 4, 1);
    cur_req = "R4"; set_time(24, 2, 29, 23, 59, 58); idle(TPS * 4, 1);
    cur_req = "R4"; set_time(23, 4, 30, 23, 59, 58); idle(TPS * 4, 1);
    cur_req = "R4"; set_time(23, 12, 31, 23, 59, 58); idle(TPS * 4, 1);
    cur_req = "R4"; set_time(99, 12, 31, 23, 59, 58); idle(TPS * 4, 1);
    cur_req = "R5"; idle(TPS * 3 * 3, 3);      // sparse ticks, long busy window
    cur_req = "R8"; wr(8'h00, 8'h59); collide(8'h00, 8'h30); idle(6, 1);
    cur_req = "R8"; wr(8'h00, 8'h59); collide(8'h04, 8'h42); idle(6, 1);
    cur_req = "R6"; wr(8'h44, 8'h3C); idle(6, 1000);
    cur_req = "R6"; collide(8'h44, 8'h3C); idle(6, 1000);
    cur_req = "R6"; wr(8'h44, 8'h04); idle(6, 1000);
    cur_req = "R10"; wr(8'h1C, 8'h55); wr(8'h60, 8'hFF); wr(8'h4C, 8'hFF); wr(8'h01, 8'h77);
    idle(20, 1000);
    cur_req = "R2"; idle(3, 1); wr(8'h40, 8'h00); idle(30, 1);
    idle(2, 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule